// File: doc/BRIEF.md
# BPSK Subcarrier Soft Demodulator

This block sits behind a pair of correlators that deliver one signed in-phase and one signed quadrature sample for every half bit of a phase-modulated subcarrier. It decides when a subcarrier is present and learns which phase stands for logic 1. It then follows the start-of-frame pattern and turns the following characters into bytes. Each character is ten bits: a start bit, eight data bits sent least significant first, and a stop bit. A character of ten zero bits closes the frame.

Phase tracking is cheap. The reference is kept only as the signs of two running sums, so each sample is scored by adding or subtracting its I and Q parts. Signal strength is estimated from the larger magnitude plus half the smaller one, which needs no multiplier and no square root. Every timing window in the frame search is counted in samples and set by a parameter. Any window that is broken sends the block back to searching and gives a one-cycle drop pulse. An input `halfScale` halves both sample components before any other processing, for use when the block listens as a monitor.

Top module: `bpsk_soft_demod`

## Requirements
- R1: A sample is only taken when `sampleValid` is high. Signal strength is the larger of |I| and |Q| plus the smaller one shifted right by one. The search leaves idle only when this value is strictly greater than 8. So (8,0) and (6,5) are never detected, while (8,2) and (6,6) are.
- R2: Reference training adds I and Q of 8 consecutive detected samples into two sums, counting the first detected sample. A sample that is not detected during training raises `dropOut` and returns to idle, and `active` stays low.
- R3: The score of a sample is +I when the I sum is greater than zero and -I otherwise, plus +Q or -Q chosen the same way from the Q sum. A score greater than zero is high and any other score is low. Frames decode with the reference in any quadrant.
- R4: After training, up to 50 high samples are accepted before the first low sample. The 51st high sample raises `dropOut`.
- R5: The start-of-frame low run counts the consecutive low samples, including the first one. A high sample that ends a run shorter than 18 raises `dropOut`. A 25th low sample also raises `dropOut`. A run of 18 to 24 samples is accepted, and the high sample that ends it makes `active` go high.
- R6: While the block waits for a start bit, which happens after the start-of-frame and after every character, up to 6 high samples are allowed; the high sample that ends the low run is not counted. The 7th high sample raises `dropOut`. A low sample begins a character.
- R7: Each bit is decided by the sign of the sum of its two half-bit scores. The sample that detected the start bit is the first half of that bit. A bit whose halves disagree takes the sign of the larger half.
- R8: A character whose bit 9 (stop) is 1 and whose bit 0 (start) is 0 puts data bits 1 to 8 on `byteData`, with bit 1 as the LSB. `byteValid` is high for one cycle, in the cycle after the last sample of the character. Any other character that is not all zero raises `dropOut` and gives no byte.
- R9: A character of ten zero bits raises `frameDone` for one cycle, in the cycle after its last sample, even in a frame with no bytes. `active` falls in the same cycle and the block returns to idle.
- R10: `active` is high from the accepted start-of-frame until the frame ends or is dropped. `byteValid`, `frameDone` and `dropOut` are never high together.
- R11: Cycles with `sampleValid` low change nothing, whatever I and Q hold in those cycles.
- R12: With `halfScale` high, both components are shifted right arithmetically by one before any use. The (12,6) reference is then too weak to detect, although without scaling it decodes.
- R13: While `rstN` is low and just after, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Marks a new I/Q half-bit sample |
| sampleI | input | SAMPLE_W | Signed in-phase correlator value |
| sampleQ | input | SAMPLE_W | Signed quadrature correlator value |
| halfScale | input | 1 | Halves both components when high |
| byteValid | output | 1 | One-cycle strobe for a received byte |
| byteData | output | CHAR_BITS-2 | Received byte |
| frameDone | output | 1 | One-cycle strobe on the end-of-frame character |
| dropOut | output | 1 | One-cycle strobe when synchronisation is lost |
| active | output | 1 | High while the block is inside a frame |

## Verification
The hardest conditions to reach are the exact edges of the timing windows. These are the 50th against the 51st preamble sample, a low run of 17, 18, 24 or 25 samples, and 6 against 7 high samples before a start bit. Each needs a correctly trained reference first and must be produced to the exact sample. The bench builds every frame sample by sample from run-length tasks, so the length of each run is set exactly. It ends a faulty frame right at the sample that breaks the window, so that a retrain from the following samples cannot hide the drop. Bits with halves that disagree, and frames sent with the reference in each quadrant, check the soft-decision arithmetic on its own.

// File: rtl/bpsk_soft_demod_pkg.sv
package bpsk_soft_demod_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRAIN,
    ST_PREAMBLE,
    ST_SOF_LOW,
    ST_GAP,
    ST_DATA
  } demodState_t;

  typedef struct packed {
    logic loadRef;
    logic addRef;
    logic latchHalf;
    logic clearShift;
    logic shiftBit;
  } dpCtrl_t;

endpackage

// File: rtl/bpsk_soft_demod_datapath.sv
module bpsk_soft_demod_datapath
  import bpsk_soft_demod_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int TRAIN_LEN  = 8,
  parameter int AMP_THRESH = 8,
  parameter int CHAR_BITS  = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleI,
  input  logic signed [SAMPLE_W-1:0] sampleQ,
  input  logic                       halfScale,
  input  dpCtrl_t                    ctrl,
  output logic                       ampOk,
  output logic                       softHigh,
  output logic [CHAR_BITS-1:0]       nextShift
);

  localparam int EXT_W    = SAMPLE_W + 1;
  localparam int AMP_W    = EXT_W + 1;
  localparam int ACC_W    = SAMPLE_W + $clog2(TRAIN_LEN) + 1;
  localparam int SOFT_W   = SAMPLE_W + 2;
  localparam int BITSUM_W = SOFT_W + 1;

  logic signed [SAMPLE_W-1:0] inI, inQ;
  logic signed [EXT_W-1:0]    extI, extQ;
  logic [EXT_W-1:0]           absI, absQ, bigMag, smallMag;
  logic [AMP_W-1:0]           amp;
  logic signed [ACC_W-1:0]    sumI, sumQ;
  logic signed [SOFT_W-1:0]   termI, termQ, softVal, halfAcc;
  logic signed [BITSUM_W-1:0] bitSum;
  logic [CHAR_BITS-1:0]       shiftReg;

  // optional halving for monitor use
  always_comb begin
    inI = halfScale ? (sampleI >>> 1) : sampleI;
    inQ = halfScale ? (sampleQ >>> 1) : sampleQ;
    extI = EXT_W'(inI);
    extQ = EXT_W'(inQ);
  end

  // magnitude estimate: larger plus half the smaller
  always_comb begin
    absI = extI[EXT_W-1] ? EXT_W'(-extI) : EXT_W'(extI);
    absQ = extQ[EXT_W-1] ? EXT_W'(-extQ) : EXT_W'(extQ);
    bigMag   = (absI > absQ) ? absI : absQ;
    smallMag = (absI > absQ) ? absQ : absI;
    amp   = AMP_W'(bigMag) + AMP_W'(smallMag >> 1);
    ampOk = amp > AMP_W'(AMP_THRESH);
  end

  // quadrant-only reference sums
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumI <= '0;
      sumQ <= '0;
    end else if (ctrl.loadRef) begin
      sumI <= ACC_W'(extI);
      sumQ <= ACC_W'(extQ);
    end else if (ctrl.addRef) begin
      sumI <= sumI + ACC_W'(extI);
      sumQ <= sumQ + ACC_W'(extQ);
    end
  end

  always_comb begin
    termI    = (sumI > 0) ? SOFT_W'(extI) : -SOFT_W'(extI);
    termQ    = (sumQ > 0) ? SOFT_W'(extQ) : -SOFT_W'(extQ);
    softVal  = termI + termQ;
    softHigh = softVal > 0;
    bitSum   = BITSUM_W'(halfAcc) + BITSUM_W'(softVal);
    nextShift = {bitSum > 0, shiftReg[CHAR_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfAcc  <= '0;
      shiftReg <= '0;
    end else begin
      if (ctrl.latchHalf) halfAcc <= softVal;
      if (ctrl.clearShift) shiftReg <= '0;
      else if (ctrl.shiftBit) shiftReg <= nextShift;
    end
  end

endmodule

// File: rtl/bpsk_soft_demod_control.sv
module bpsk_soft_demod_control
  import bpsk_soft_demod_pkg::*;
#(
  parameter int TRAIN_LEN      = 8,
  parameter int SOF_WAIT_MAX   = 50,
  parameter int SOF_LOW_MIN    = 18,
  parameter int SOF_LOW_MAX    = 24,
  parameter int START_WAIT_MAX = 6,
  parameter int CHAR_BITS      = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleValid,
  input  logic                 ampOk,
  input  logic                 softHigh,
  input  logic [CHAR_BITS-1:0] nextShift,
  output dpCtrl_t              ctrl,
  output logic                 byteValid,
  output logic [CHAR_BITS-3:0] byteData,
  output logic                 frameDone,
  output logic                 dropOut,
  output logic                 active
);

  localparam int MAX_A   = (SOF_WAIT_MAX > SOF_LOW_MAX) ? SOF_WAIT_MAX : SOF_LOW_MAX;
  localparam int MAX_B   = (START_WAIT_MAX > TRAIN_LEN) ? START_WAIT_MAX : TRAIN_LEN;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = $clog2(CHAR_BITS + 1);

  demodState_t        state, stateNext;
  logic [CNT_W-1:0]   cnt, cntNext;
  logic [BIT_W-1:0]   bitCnt, bitCntNext;
  logic               half, halfNext;
  logic               emitByte, emitDone, emitDrop;

  always_comb begin
    stateNext  = state;
    cntNext    = cnt;
    bitCntNext = bitCnt;
    halfNext   = half;
    ctrl       = '0;
    emitByte   = 1'b0;
    emitDone   = 1'b0;
    emitDrop   = 1'b0;
    if (sampleValid) begin
      unique case (state)
        ST_IDLE: begin
          if (ampOk) begin
            ctrl.loadRef = 1'b1;
            cntNext      = CNT_W'(1);
            stateNext    = ST_TRAIN;
          end
        end
        ST_TRAIN: begin
          if (!ampOk) begin
            emitDrop  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            ctrl.addRef = 1'b1;
            if (cnt == CNT_W'(TRAIN_LEN - 1)) begin
              stateNext = ST_PREAMBLE;
              cntNext   = '0;
            end else begin
              cntNext = cnt + CNT_W'(1);
            end
          end
        end
        ST_PREAMBLE: begin
          if (!softHigh) begin
            stateNext = ST_SOF_LOW;
            cntNext   = CNT_W'(1);
          end else if (cnt == CNT_W'(SOF_WAIT_MAX)) begin
            emitDrop  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            cntNext = cnt + CNT_W'(1);
          end
        end
        ST_SOF_LOW: begin
          if (softHigh) begin
            if (cnt < CNT_W'(SOF_LOW_MIN)) begin
              emitDrop  = 1'b1;
              stateNext = ST_IDLE;
            end else begin
              stateNext = ST_GAP;
              cntNext   = '0;
            end
          end else if (cnt == CNT_W'(SOF_LOW_MAX)) begin
            emitDrop  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            cntNext = cnt + CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (!softHigh) begin
            ctrl.latchHalf  = 1'b1;
            ctrl.clearShift = 1'b1;
            bitCntNext      = '0;
            halfNext        = 1'b1;
            stateNext       = ST_DATA;
          end else if (cnt == CNT_W'(START_WAIT_MAX)) begin
            emitDrop  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            cntNext = cnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (!half) begin
            ctrl.latchHalf = 1'b1;
            halfNext       = 1'b1;
          end else begin
            ctrl.shiftBit = 1'b1;
            halfNext      = 1'b0;
            if (bitCnt == BIT_W'(CHAR_BITS - 1)) begin
              if (nextShift[CHAR_BITS-1] && !nextShift[0]) begin
                emitByte  = 1'b1;
                stateNext = ST_GAP;
                cntNext   = '0;
              end else if (nextShift == '0) begin
                emitDone  = 1'b1;
                stateNext = ST_IDLE;
              end else begin
                emitDrop  = 1'b1;
                stateNext = ST_IDLE;
              end
            end else begin
              bitCntNext = bitCnt + BIT_W'(1);
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitCnt    <= '0;
      half      <= 1'b0;
      byteValid <= 1'b0;
      byteData  <= '0;
      frameDone <= 1'b0;
      dropOut   <= 1'b0;
    end else begin
      state     <= stateNext;
      cnt       <= cntNext;
      bitCnt    <= bitCntNext;
      half      <= halfNext;
      byteValid <= emitByte;
      frameDone <= emitDone;
      dropOut   <= emitDrop;
      if (emitByte) byteData <= nextShift[CHAR_BITS-2:1];
    end
  end

  assign active = (state == ST_GAP) || (state == ST_DATA);

endmodule

// File: rtl/bpsk_soft_demod.sv
module bpsk_soft_demod
  import bpsk_soft_demod_pkg::*;
#(
  parameter int SAMPLE_W       = 8,
  parameter int TRAIN_LEN      = 8,
  parameter int AMP_THRESH     = 8,
  parameter int SOF_WAIT_MAX   = 50,
  parameter int SOF_LOW_MIN    = 18,
  parameter int SOF_LOW_MAX    = 24,
  parameter int START_WAIT_MAX = 6,
  parameter int CHAR_BITS      = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleI,
  input  logic signed [SAMPLE_W-1:0] sampleQ,
  input  logic                       halfScale,
  output logic                       byteValid,
  output logic [CHAR_BITS-3:0]       byteData,
  output logic                       frameDone,
  output logic                       dropOut,
  output logic                       active
);

  dpCtrl_t              ctrl;
  logic                 ampOk;
  logic                 softHigh;
  logic [CHAR_BITS-1:0] nextShift;

  bpsk_soft_demod_datapath #(
    .SAMPLE_W  (SAMPLE_W),
    .TRAIN_LEN (TRAIN_LEN),
    .AMP_THRESH(AMP_THRESH),
    .CHAR_BITS (CHAR_BITS)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .sampleI  (sampleI),
    .sampleQ  (sampleQ),
    .halfScale(halfScale),
    .ctrl     (ctrl),
    .ampOk    (ampOk),
    .softHigh (softHigh),
    .nextShift(nextShift)
  );

  bpsk_soft_demod_control #(
    .TRAIN_LEN     (TRAIN_LEN),
    .SOF_WAIT_MAX  (SOF_WAIT_MAX),
    .SOF_LOW_MIN   (SOF_LOW_MIN),
    .SOF_LOW_MAX   (SOF_LOW_MAX),
    .START_WAIT_MAX(START_WAIT_MAX),
    .CHAR_BITS     (CHAR_BITS)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .ampOk      (ampOk),
    .softHigh   (softHigh),
    .nextShift  (nextShift),
    .ctrl       (ctrl),
    .byteValid  (byteValid),
    .byteData   (byteData),
    .frameDone  (frameDone),
    .dropOut    (dropOut),
    .active     (active)
  );

endmodule

// File: rtl/bpsk_soft_demod_checker.sv
module bpsk_soft_demod_checker (
  input logic clk,
  input logic rstN,
  input logic sampleValid,
  input logic byteValid,
  input logic frameDone,
  input logic dropOut,
  input logic active
);

  // R10: at most one result strobe per cycle
  assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({byteValid, frameDone, dropOut}));

  // R8: a byte leaves the block only inside a frame
  assert_byte_in_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> active);

  // R8: byte strobe lasts one cycle
  assert_byte_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R9: end of frame leaves the frame
  assert_done_clears_active_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !active);

  // R11: idle cycles produce no strobes
  assert_idle_no_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> (!byteValid && !frameDone && !dropOut));

  // R11: idle cycles keep the frame flag
  assert_idle_active_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(active));

  // R5: entering a frame needs a sample
  assert_active_rise_on_sample_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(sampleValid));

endmodule

bind bpsk_soft_demod bpsk_soft_demod_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .byteValid  (byteValid),
  .frameDone  (frameDone),
  .dropOut    (dropOut),
  .active     (active)
);

// File: tb/bpsk_soft_demod_bench.sv
module bpsk_soft_demod_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleValid = 1'b0;
  logic [7:0] sampleI = 8'h00;
  logic [7:0] sampleQ = 8'h00;
  logic       halfScale = 1'b0;
  logic       byteValid;
  logic [7:0] byteData;
  logic       frameDone;
  logic       dropOut;
  logic       active;

  always #10 clk = ~clk;

  bpsk_soft_demod u_bpsk_soft_demod (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sampleI    (sampleI),
    .sampleQ    (sampleQ),
    .halfScale  (halfScale),
    .byteValid  (byteValid),
    .byteData   (byteData),
    .frameDone  (frameDone),
    .dropOut    (dropOut),
    .active     (active)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  // monitor: log strobes at the falling edge
  logic [7:0] byteLog [0:127];
  int byteTotal = 0;
  int frameTotal = 0;
  int dropTotal = 0;
  int activeCycles = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid) begin
        if (byteTotal < 128) byteLog[byteTotal] = byteData;
        byteTotal++;
      end
      if (frameDone) frameTotal++;
      if (dropOut) dropTotal++;
      if (active) activeCycles++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int refI = 40;
  int refQ = 20;

  task automatic sendSample(input int si, input int sq);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleI = si[7:0];
    sampleQ = sq[7:0];
    @(negedge clk);
    sampleValid = 1'b0;
    sampleI = 8'h9c;   // garbage while not valid
    sampleQ = 8'h9c;
  endtask

  task automatic sendLevel(input bit b, input int n);
    for (int i = 0; i < n; i++) begin
      if (b) sendSample(refI, refQ);
      else   sendSample(-refI, -refQ);
    end
  endtask

  task automatic sendSplitBit(input bit b);
    if (b) begin
      sendSample(refI, refQ);
      sendSample(-refI / 4, -refQ / 4);
    end else begin
      sendSample(-refI, -refQ);
      sendSample(refI / 4, refQ / 4);
    end
  endtask

  task automatic sendChar(input logic [7:0] d, input bit stopBit, input bit split);
    sendLevel(1'b0, 2);
    for (int i = 0; i < 8; i++) begin
      if (split) sendSplitBit(d[i]);
      else sendLevel(d[i], 2);
    end
    sendLevel(stopBit, 2);
  endtask

  task automatic sendHead(input int nPre, input int nLow, input int nGap);
    sendLevel(1'b1, 8 + nPre);
    sendLevel(1'b0, nLow);
    sendLevel(1'b1, nGap);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) sendSample(0, 0);
  endtask

  int b0, f0, d0, a0;
  task automatic snap();
    b0 = byteTotal; f0 = frameTotal; d0 = dropTotal; a0 = activeCycles;
  endtask

  // table: {refI, refQ, byte0, byte1}
  localparam logic [31:0] FRAME_TBL [0:3] = '{
    {8'd40,  8'd20,  8'hA5, 8'h3C},
    {8'hE2,  8'd50,  8'h00, 8'hFF},
    {8'hC4,  8'hF6,  8'h81, 8'h7E},
    {8'd25,  8'hD3,  8'h5A, 8'hC3}
  };

  initial begin
    // R13 reset state
    repeat (3) @(negedge clk);
    checkEq("R13 byteValid in reset", int'(byteValid), 0);
    checkEq("R13 frameDone in reset", int'(frameDone), 0);
    checkEq("R13 dropOut in reset", int'(dropOut), 0);
    checkEq("R13 active in reset", int'(active), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R13 active after reset", int'(active), 0);

    // R3 R8 table of frames in all quadrants
    for (int k = 0; k < 4; k++) begin
      refI = int'($signed(FRAME_TBL[k][31:24]));
      refQ = int'($signed(FRAME_TBL[k][23:16]));
      snap();
      sendHead(20, 20, 3);
      sendChar(FRAME_TBL[k][15:8], 1'b1, 1'b0);
      sendLevel(1'b1, 2);
      sendChar(FRAME_TBL[k][7:0], 1'b1, 1'b0);
      sendLevel(1'b0, 20);
      quiet(3);
      checkEq("R3 table byte count", byteTotal - b0, 2);
      checkEq("R8 table byte0", int'(byteLog[b0]), int'(FRAME_TBL[k][15:8]));
      checkEq("R8 table byte1", int'(byteLog[b0 + 1]), int'(FRAME_TBL[k][7:0]));
      checkEq("R9 table frame done", frameTotal - f0, 1);
      checkEq("R3 table no drop", dropTotal - d0, 0);
    end

    refI = 40; refQ = 20;

    // R7 split half bits
    snap();
    sendHead(10, 20, 2);
    sendChar(8'h96, 1'b1, 1'b1);
    sendLevel(1'b0, 20);
    quiet(2);
    checkEq("R7 split-half byte", int'(byteLog[b0]), 8'h96);
    checkEq("R7 split-half count", byteTotal - b0, 1);

    // R9 R10 empty frame, exact frameDone cycle
    snap();
    sendLevel(1'b1, 8);
    checkEq("R10 active low after training", int'(active), 0);
    sendLevel(1'b1, 5);
    sendLevel(1'b0, 20);
    sendLevel(1'b1, 1);
    checkEq("R10 active after SOF", int'(active), 1);
    sendLevel(1'b0, 19);
    @(negedge clk);
    sampleValid = 1'b1; sampleI = 8'(-refI); sampleQ = 8'(-refQ);
    @(negedge clk);
    sampleValid = 1'b0;
    checkEq("R9 frameDone cycle after last sample", int'(frameDone), 1);
    checkEq("R9 active falls with frameDone", int'(active), 0);
    @(negedge clk);
    checkEq("R9 frameDone one cycle", int'(frameDone), 0);
    checkEq("R9 empty frame bytes", byteTotal - b0, 0);
    quiet(2);

    // R1 threshold boundary
    refI = 8; refQ = 0;
    snap();
    sendHead(5, 20, 2); sendChar(8'h11, 1'b1, 1'b0); sendLevel(1'b0, 20); quiet(2);
    checkEq("R1 amplitude 8 ignored frames", frameTotal - f0, 0);
    checkEq("R1 amplitude 8 never active", activeCycles - a0, 0);
    refI = 6; refQ = 5;
    snap();
    sendHead(5, 20, 2); sendChar(8'h11, 1'b1, 1'b0); sendLevel(1'b0, 20); quiet(2);
    checkEq("R1 estimate (6,5) ignored", frameTotal - f0 + byteTotal - b0, 0);
    refI = 8; refQ = 2;
    snap();
    sendHead(5, 20, 2); sendChar(8'h22, 1'b1, 1'b0); sendLevel(1'b0, 20); quiet(2);
    checkEq("R1 amplitude 9 decodes", int'(byteLog[b0]), 8'h22);
    refI = 6; refQ = 6;
    snap();
    sendHead(5, 20, 2); sendChar(8'h33, 1'b1, 1'b0); sendLevel(1'b0, 20); quiet(2);
    checkEq("R1 estimate (6,6) decodes", frameTotal - f0, 1);

    // R12 half scaling
    refI = 12; refQ = 6;
    snap();
    sendHead(5, 20, 2); sendChar(8'h44, 1'b1, 1'b0); sendLevel(1'b0, 20); quiet(2);
    checkEq("R12 (12,6) unscaled decodes", frameTotal - f0, 1);
    halfScale = 1'b1;
    snap();
    sendHead(5, 20, 2); sendChar(8'h44, 1'b1, 1'b0); sendLevel(1'b0, 20); quiet(2);
    checkEq("R12 (12,6) scaled not detected", frameTotal - f0 + byteTotal - b0 + dropTotal - d0, 0);
    refI = 40; refQ = 20;
    snap();
    sendHead(5, 20, 2); sendChar(8'h5C, 1'b1, 1'b0); sendLevel(1'b0, 20); quiet(2);
    checkEq("R12 scaled strong decodes", int'(byteLog[b0]), 8'h5C);
    halfScale = 1'b0;

    // R2 training loss
    snap();
    sendLevel(1'b1, 4); quiet(3);
    checkEq("R2 training loss drop", dropTotal - d0, 1);
    checkEq("R2 training loss inactive", activeCycles - a0, 0);

    // R4 preamble window
    snap();
    sendHead(50, 20, 2); sendChar(8'h61, 1'b1, 1'b0); sendLevel(1'b0, 20); quiet(2);
    checkEq("R4 50 preamble samples ok", int'(byteLog[b0]), 8'h61);
    snap();
    sendLevel(1'b1, 8 + 51); quiet(2);
    checkEq("R4 51 preamble samples drop", dropTotal - d0, 1);

    // R5 SOF low bounds
    snap();
    sendHead(5, 18, 2); sendChar(8'h72, 1'b1, 1'b0); sendLevel(1'b0, 20); quiet(2);
    checkEq("R5 low 18 accepted", int'(byteLog[b0]), 8'h72);
    snap();
    sendHead(5, 24, 2); sendChar(8'h73, 1'b1, 1'b0); sendLevel(1'b0, 20); quiet(2);
    checkEq("R5 low 24 accepted", int'(byteLog[b0]), 8'h73);
    snap();
    sendHead(5, 17, 1); quiet(2);
    checkEq("R5 low 17 drop", dropTotal - d0, 1);
    checkEq("R5 low 17 inactive", activeCycles - a0, 0);
    snap();
    sendHead(5, 25, 0); quiet(2);
    checkEq("R5 low 25 drop", dropTotal - d0, 1);

    // R6 start-bit wait
    snap();
    sendHead(5, 20, 7); sendChar(8'h84, 1'b1, 1'b0);
    sendLevel(1'b1, 6); sendChar(8'h85, 1'b1, 1'b0);
    sendLevel(1'b0, 20); quiet(2);
    checkEq("R6 six highs accepted", byteTotal - b0, 2);
    checkEq("R6 second byte", int'(byteLog[b0 + 1]), 8'h85);
    snap();
    sendHead(5, 20, 8); quiet(2);
    checkEq("R6 seven highs drop", dropTotal - d0, 1);

    // R8 bad stop bit
    snap();
    sendHead(5, 20, 2); sendChar(8'h90, 1'b1, 1'b0); sendChar(8'h55, 1'b0, 1'b0); quiet(3);
    checkEq("R8 good byte before bad", byteTotal - b0, 1);
    checkEq("R8 bad stop drop", dropTotal - d0, 1);
    checkEq("R8 bad stop no frame", frameTotal - f0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule